// File: doc/BRIEF.md
# Rate-Adaptive OFDM Subcarrier Mapper

This block sits between the bit-level stages of an OFDM transmitter and its inverse transform. It takes 48-bit frames over a valid/ready input. Each frame carries a 2-bit rate code. The block gathers as many frames as one symbol needs at that rate. It then presents the whole symbol at once: 64 complex frequency-domain tones, each part a 16-bit Q15 value.

Depending on the rate, each data tone carries one, two or four bits, as BPSK, QPSK or Gray-coded 16-QAM. A full symbol therefore consumes one, two or four frames. Four fixed tone positions carry pilots, twelve positions stay at zero, and the remaining 48 positions carry data. The symbol stays in an output register until the downstream stage takes it. While the symbol is waiting there, no new frame is accepted.

Top module: `tone_mapper`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Rate code 0 or 3 completes a symbol with 1 frame, code 1 with 2 frames and code 2 with 4 frames. `out_valid` rises on the clock edge that accepts the last frame of a symbol, and not before.
- R3: While `out_valid` is 1, `in_ready` is 0. A frame offered in that state is not absorbed. `out_re` and `out_im` hold steady until an edge with `out_ready` high clears `out_valid`.
- R4: Tone 0 and tones 27 to 37 have real and imaginary parts both 0.
- R5: Tones 7, 43 and 57 have a real part of 0x7FFF, and tone 21 has a real part of 0x8000. All four pilots have an imaginary part of 0.
- R6: Under code 0, data tone d takes bit d. A 1 gives a real part of 0x7FFF and a 0 gives 0x8000. The imaginary part is 0.
- R7: Under code 1, data tone d takes bit 2d for the real axis and bit 2d+1 for the imaginary axis. A 1 gives +0x5A82 and a 0 gives -0x5A82.
- R8: Under code 2, data tone d takes bits 4d and 4d+1 for the real axis and bits 4d+2 and 4d+3 for the imaginary axis. For each axis, the higher bit of the pair picks the sign (1 means positive). The lower bit picks the magnitude: 1 gives 0x287A and 0 gives 0x796E.
- R9: Data tones are the non-null, non-pilot positions taken in ascending tone index. Bit k of the symbol is bit k mod 48 of frame floor(k/48) of that symbol, so later frames continue where earlier frames stop.
- R10: The rate code that arrives with the first frame of a symbol governs the whole symbol. Codes on the later frames of that symbol are ignored.
- R11: Code 3 behaves exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Frame offered |
| in_ready | output | 1 | Frame can be taken |
| in_rate | input | 2 | Rate code of the offered frame |
| in_data | input | 48 | Frame bits |
| out_valid | output | 1 | Symbol available |
| out_ready | input | 1 | Downstream takes the symbol |
| out_re | output | 1024 | Real parts; tone t at bits [16t+15:16t] |
| out_im | output | 1024 | Imaginary parts; tone t at bits [16t+15:16t] |

## Verification
The assertions assume that `out_ready` is a plain level and that the upstream stage offers a frame only as a valid/ready request. They also assume that, once the first frame of a symbol is in, the rest of that symbol follows without any reset in between. The stimulus drives every frame on a falling edge and never changes a request halfway through a cycle. It deliberately places mismatched rate codes on the later frames and offers junk frames while a symbol is still held. Sweeps cover every rate code against constant, alternating, counting and pseudo-random bit patterns. Because of the counting pattern, every QPSK pair and every 16-QAM nibble reaches a data tone.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

   localparam int N_TONES    = 64;
   localparam int N_DATA     = 48;
   localparam int MAX_FRAMES = 4;

   typedef enum logic [1:0] {
      RT_BPSK  = 2'd0,
      RT_QPSK  = 2'd1,
      RT_QAM16 = 2'd2,
      RT_ALIAS = 2'd3
   } rate_t;

   typedef enum logic [1:0] {
      TK_NULL  = 2'd0,
      TK_PILOT = 2'd1,
      TK_DATA  = 2'd2
   } tone_kind_t;

   localparam logic [15:0] Q_ONE_P  = 16'h7FFF;
   localparam logic [15:0] Q_ONE_N  = 16'h8000;
   localparam logic [15:0] Q_QPSK_P = 16'h5A82;
   localparam logic [15:0] Q_QPSK_N = 16'hA57E;
   localparam logic [15:0] Q_QAM1_P = 16'h287A;
   localparam logic [15:0] Q_QAM1_N = 16'hD786;
   localparam logic [15:0] Q_QAM3_P = 16'h796E;
   localparam logic [15:0] Q_QAM3_N = 16'h8692;

   function automatic tone_kind_t kind_of(input int t);
      if (t == 0 || (t >= 27 && t <= 37)) return TK_NULL;
      if (t == 7 || t == 21 || t == 43 || t == 57) return TK_PILOT;
      return TK_DATA;
   endfunction

   function automatic int data_slot(input int t);
      int n;
      n = 0;
      for (int k = 0; k < t; k++)
         if (kind_of(k) == TK_DATA) n++;
      return n;
   endfunction

   function automatic logic [2:0] frames_for(input rate_t r);
      case (r)
         RT_QPSK:  return 3'd2;
         RT_QAM16: return 3'd4;
         default:  return 3'd1;
      endcase
   endfunction

   function automatic rate_t norm_rate(input logic [1:0] c);
      return (c == 2'd3) ? RT_BPSK : rate_t'(c);
   endfunction

   // pair[1] = sign, pair[0] = inner magnitude
   function automatic logic [15:0] qam_axis(input logic [1:0] pair);
      case (pair)
         2'b00:   return Q_QAM3_N;
         2'b01:   return Q_QAM1_N;
         2'b11:   return Q_QAM1_P;
         default: return Q_QAM3_P;
      endcase
   endfunction

endpackage

// File: rtl/mapper_collect.sv
module mapper_collect
   import mapper_pkg::*;
#(
   parameter int FRAME_W = 48,
   localparam int BUF_W  = FRAME_W * MAX_FRAMES,
   localparam int CNT_W  = $clog2(MAX_FRAMES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic [1:0]         rate_code,
   input  logic [FRAME_W-1:0] frame,
   output logic [BUF_W-1:0]   merged,
   output rate_t              eff_rate,
   output logic               last
);

   logic [BUF_W-1:0] buf_q;
   logic [CNT_W-1:0] cnt_q;
   rate_t            rate_q;
   logic [2:0]       need;

   assign eff_rate = (cnt_q == '0) ? norm_rate(rate_code) : rate_q;
   assign need     = frames_for(eff_rate);
   assign last     = ({1'b0, cnt_q} == need - 3'd1);

   always_comb begin
      merged = buf_q;
      merged[cnt_q*FRAME_W +: FRAME_W] = frame;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         cnt_q  <= '0;
         rate_q <= RT_BPSK;
      end else if (take) begin
         buf_q <= merged;
         if (cnt_q == '0) rate_q <= norm_rate(rate_code);
         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> ({1'b0, cnt_q} < frames_for(rate_q)));

   // R10
   rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cnt_q != '0) |=> $stable(rate_q));

endmodule

// File: rtl/mapper_tones.sv
module mapper_tones
   import mapper_pkg::*;
#(
   parameter int FRAME_W = 48,
   parameter int SAMP_W  = 16,
   localparam int BUF_W  = FRAME_W * MAX_FRAMES,
   localparam int OUT_W  = N_TONES * SAMP_W
) (
   input  rate_t            rate,
   input  logic [BUF_W-1:0] bits,
   output logic [OUT_W-1:0] re,
   output logic [OUT_W-1:0] im
);

   for (genvar t = 0; t < N_TONES; t++) begin : g_tone
      localparam tone_kind_t KIND = kind_of(t);
      if (KIND == TK_NULL) begin : g_null
         assign re[t*SAMP_W +: SAMP_W] = '0;
         assign im[t*SAMP_W +: SAMP_W] = '0;
      end else if (KIND == TK_PILOT) begin : g_pilot
         assign re[t*SAMP_W +: SAMP_W] = (t == 21) ? Q_ONE_N : Q_ONE_P;
         assign im[t*SAMP_W +: SAMP_W] = '0;
      end else begin : g_data
         localparam int D = data_slot(t);
         logic [SAMP_W-1:0] r_v, i_v;
         always_comb begin
            case (rate)
               RT_QPSK: begin
                  r_v = bits[2*D]   ? Q_QPSK_P : Q_QPSK_N;
                  i_v = bits[2*D+1] ? Q_QPSK_P : Q_QPSK_N;
               end
               RT_QAM16: begin
                  r_v = qam_axis(bits[4*D +: 2]);
                  i_v = qam_axis(bits[4*D+2 +: 2]);
               end
               default: begin
                  r_v = bits[D] ? Q_ONE_P : Q_ONE_N;
                  i_v = '0;
               end
            endcase
         end
         assign re[t*SAMP_W +: SAMP_W] = r_v;
         assign im[t*SAMP_W +: SAMP_W] = i_v;
      end
   end

endmodule

// File: rtl/tone_mapper.sv
module tone_mapper
   import mapper_pkg::*;
#(
   parameter int FRAME_W = 48,
   parameter int SAMP_W  = 16,
   localparam int BUF_W  = FRAME_W * MAX_FRAMES,
   localparam int OUT_W  = N_TONES * SAMP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [1:0]         in_rate,
   input  logic [FRAME_W-1:0] in_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [OUT_W-1:0]   out_re,
   output logic [OUT_W-1:0]   out_im
);

   if (FRAME_W != N_DATA) begin : g_bad_frame
      $error("tone_mapper: FRAME_W must equal the data tone count");
   end
   if (SAMP_W != 16) begin : g_bad_samp
      $error("tone_mapper: SAMP_W must be 16 for Q15 constants");
   end

   logic             take, last;
   logic [BUF_W-1:0] merged;
   rate_t            eff_rate;
   logic [OUT_W-1:0] map_re, map_im;

   assign in_ready = !out_valid;
   assign take     = in_valid && in_ready;

   mapper_collect #(.FRAME_W(FRAME_W)) u_collect (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .rate_code (in_rate),
      .frame     (in_data),
      .merged    (merged),
      .eff_rate  (eff_rate),
      .last      (last)
   );

   mapper_tones #(.FRAME_W(FRAME_W), .SAMP_W(SAMP_W)) u_tones (
      .rate (eff_rate),
      .bits (merged),
      .re   (map_re),
      .im   (map_im)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
      end else if (take && last) begin
         out_valid <= 1'b1;
         out_re    <= map_re;
         out_im    <= map_im;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

   // R2
   rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid));

   // R4
   null_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_re[SAMP_W-1:0] == '0 && out_im[32*SAMP_W +: SAMP_W] == '0));

   // R5
   pilot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_re[21*SAMP_W +: SAMP_W] == Q_ONE_N && out_im[7*SAMP_W +: SAMP_W] == '0));

endmodule

// File: tb/sim_tone_mapper.sv
module sim_tone_mapper;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [1:0]    in_rate = 2'd0;
   logic [47:0]   in_data = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [1023:0] out_re, out_im;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tone_mapper u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_rate(in_rate), .in_data(in_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_re(out_re), .out_im(out_im)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int kind_ref(input int t); // 0 null, 1 pilot, 2 data
      if (t == 0 || (t >= 27 && t <= 37)) return 0;
      if (t == 7 || t == 21 || t == 43 || t == 57) return 1;
      return 2;
   endfunction

   function automatic int frames_ref(input int code);
      if (code == 1) return 2;
      if (code == 2) return 4;
      return 1;
   endfunction

   function automatic logic [191:0] pattern(input int p, input int seed);
      logic [191:0] v;
      logic [31:0]  s;
      v = '0;
      s = 32'h1234_5678 ^ (seed * 32'h9E37_79B9);
      for (int i = 0; i < 192; i++) begin
         case (p)
            0: v[i] = 1'b0;
            1: v[i] = 1'b1;
            2: v[i] = i[0];
            3: v[i] = ((i / 4) % 16) >> (i % 4);
            default: begin
               s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
               v[i] = s[0];
            end
         endcase
      end
      return v;
   endfunction

   task automatic check_symbol(input int code, input logic [191:0] bits, input string dreq);
      int d, bad_n, bad_p, bad_d;
      int er, ei, ar, ai, mag;
      longint fa, fe;
      d = 0; bad_n = 0; bad_p = 0; bad_d = 0; fa = 0; fe = 0;
      for (int t = 0; t < 64; t++) begin
         ar = $signed(out_re[t*16 +: 16]);
         ai = $signed(out_im[t*16 +: 16]);
         case (kind_ref(t))
            0: if (ar != 0 || ai != 0) bad_n++;
            1: begin
               er = (t == 21) ? -32768 : 32767;
               if (ar != er || ai != 0) bad_p++;
            end
            default: begin
               if (code == 1) begin
                  er = bits[2*d] ? 23170 : -23170;
                  ei = bits[2*d+1] ? 23170 : -23170;
               end else if (code == 2) begin
                  mag = bits[4*d] ? 10362 : 31086;
                  er = bits[4*d+1] ? mag : -mag;
                  mag = bits[4*d+2] ? 10362 : 31086;
                  ei = bits[4*d+3] ? mag : -mag;
               end else begin
                  er = bits[d] ? 32767 : -32768;
                  ei = 0;
               end
               if (ar != er || ai != ei) begin
                  if (bad_d == 0) begin fa = ar; fe = er; end
                  bad_d++;
               end
               d++;
            end
         endcase
      end
      chk(bad_n == 0, "R4 null tones", bad_n, 0);
      chk(bad_p == 0, "R5 pilot tones", bad_p, 0);
      chk(bad_d == 0, dreq, fa, fe);
   endtask

   task automatic run_symbol(input int code, input logic [191:0] bits, input bit hold);
      int nf;
      string dreq;
      nf = frames_ref(code);
      for (int f = 0; f < nf; f++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = bits[48*f +: 48];
         in_rate  = (f == 0) ? code[1:0] : 2'(code + 1 + f); // R10 mismatched later codes
         @(posedge clk); #1;
         in_valid = 1'b0;
         if (f < nf - 1) chk(out_valid == 1'b0, "R2 early valid", out_valid, 0);
      end
      chk(out_valid == 1'b1, "R2 valid after last frame", out_valid, 1);
      case (code)
         1: dreq = "R7 R9 R10 qpsk data";
         2: dreq = "R8 R9 R10 qam16 data";
         3: dreq = "R11 alias code data";
         default: dreq = "R6 bpsk data";
      endcase
      check_symbol(code, bits, dreq);
      if (hold) begin
         logic [1023:0] sr;
         sr = out_re;
         @(negedge clk);
         in_valid = 1'b1; in_data = ~bits[47:0]; in_rate = 2'd2;
         chk(in_ready == 1'b0, "R3 ready low while held", in_ready, 0);
         @(posedge clk); @(posedge clk); #1;
         chk(out_valid == 1'b1 && out_re == sr, "R3 held stable", out_valid, 1);
      end
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
      @(posedge clk); #1;
      out_ready = 1'b0;
      chk(out_valid == 1'b0, "R3 cleared by out_ready", out_valid, 0);
   endtask

   initial begin
      #12;
      chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
      chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
      @(negedge clk);
      rst_n = 1'b1;
      for (int code = 0; code < 4; code++)
         for (int p = 0; p < 5; p++)
            run_symbol(code, pattern(p, code * 7 + p), (p % 2) == 1);
      // R9 back-to-back symbols after held junk offers
      for (int k = 0; k < 4; k++)
         run_symbol(2, pattern(4, 100 + k), 1'b1);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog actual=hung expected=complete");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule